// File: doc/BRIEF.md
# PFC Ready Status Supervisor

This block watches the control state of a power factor correction stage and tells a downstream converter when it may run. It tracks whether the stage is off or active, whether a fault is present, whether the output is over its voltage limit, and whether the error amplifier is still pulling its compensation node up. From these it drives four outputs:

- a registered ready flag;
- a start-up flag;
- a switch-inhibit level for over-voltage;
- a notice to the on-time computation that the inhibit is active. That logic must then not read the switching pause as dead time and raise the on-time.

Every input is a synchronous digital level. Each one passes through a synchronizer of `SYNC_STAGES` flops before any decision uses it. All outputs are registered. An input change applied before a clock edge therefore appears at the outputs on the third rising edge with the default depth. A start-up latch is re-armed by every off phase. It is released only once the stage is active and the amplifier has stopped charging. A fault also blocks the ready flag until the next off phase.

Top module: `pfc_ready_supervisor`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `ready` = 0, `startup` = 1, `sw_inhibit` = 0 and `ovp_notice` = 0.
- R2: Whenever `run_en` is low (off phase), `startup` is set to 1. It stays 1 for as long as `run_en` stays low.
- R3: With `run_en` = 1, `startup` clears to 0 once `ea_charging` is 0. Once clear, it does not set again while `run_en` stays 1, even if `ea_charging` returns to 1.
- R4: `ready` is 1 only when all of these hold: `run_en` = 1, `fault_in` = 0, `startup` = 0, and no fault seen since the last off phase. It rises one cycle after `startup` clears.
- R5: A `fault_in` level of 1 drives `ready` to 0 on the third rising edge after the input changes.
- R6: After `fault_in` returns to 0, `ready` stays 0 until `run_en` has gone low and then high again and `startup` has cleared again.
- R7: `run_en` going low drives `ready` to 0 on the third rising edge after the change. `startup` reads 1 at that same edge.
- R8: `sw_inhibit` follows `ovp_in`, with the same latency, whether the stage is off or active.
- R9: `ovp_notice` is 1 exactly when `sw_inhibit` is 1 and `run_en` = 1. It is 0 during an off phase, even under over-voltage.
- R10: `ovp_in` has no effect on `ready` or `startup`.
- R11: Every input passes a `SYNC_STAGES`-deep synchronizer (default 2). No output changes on the first two rising edges after an input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | 1 = stage active, 0 = off phase |
| fault_in | input | 1 | 1 = fault condition present |
| ovp_in | input | 1 | 1 = output above over-voltage level |
| ea_charging | input | 1 | 1 = error amplifier still charging its compensation node |
| ready | output | 1 | Power-good flag for the downstream converter |
| startup | output | 1 | 1 = start-up phase in progress |
| sw_inhibit | output | 1 | 1 = hold the power switch open |
| ovp_notice | output | 1 | 1 = tell the on-time logic the pause is an over-voltage inhibit |

## Verification
The bench removes a fault and checks that `ready` stays low until a full off phase and a fresh start-up. A design that re-armed `ready` as soon as the fault went away would show a premature power-good. It raises over-voltage during an off phase, where `ovp_notice` must stay low, and during regulation, where `ready` and `startup` must not move. A design that tied the notice to the inhibit alone, or folded over-voltage into the ready flag, would be caught there. It also counts edges after a fault and after an off request. This exposes a synchronizer that is too shallow, or an unregistered output that changes early.

// File: rtl/pfc_ready_supervisor.sv
module pfc_ready_supervisor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic fault_in,
  input  logic ovp_in,
  input  logic ea_charging,
  output logic ready,
  output logic startup,
  output logic sw_inhibit,
  output logic ovp_notice
);

  localparam int NIN = 4;
  localparam int LAST = SYNC_STAGES - 1;

  logic [NIN-1:0] sync_q [SYNC_STAGES];
  logic s_run, s_fault, s_ovp, s_chg;
  logic startup_q, fault_seen_q, ready_q, inhibit_q, notice_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= {run_en, fault_in, ovp_in, ea_charging};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign {s_run, s_fault, s_ovp, s_chg} = sync_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      startup_q    <= 1'b1;
      fault_seen_q <= 1'b0;
      ready_q      <= 1'b0;
      inhibit_q    <= 1'b0;
      notice_q     <= 1'b0;
    end else begin
      if (!s_run)      startup_q <= 1'b1;
      else if (!s_chg) startup_q <= 1'b0;

      if (s_fault)     fault_seen_q <= 1'b1;
      else if (!s_run) fault_seen_q <= 1'b0;

      ready_q   <= s_run && !s_fault && !startup_q && !fault_seen_q;
      inhibit_q <= s_ovp;
      notice_q  <= s_ovp && s_run;
    end
  end

  assign ready      = ready_q;
  assign startup    = startup_q;
  assign sw_inhibit = inhibit_q;
  assign ovp_notice = notice_q;

  // R7
  off_kills_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_run |=> !ready);

  // R5
  fault_kills_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_fault |=> !ready);

  // R2
  off_arms_startup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_run |=> startup);

  // R4
  ready_excl_startup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !startup);

  // R8
  ovp_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ovp |=> sw_inhibit);

  // R9
  notice_needs_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_notice |-> sw_inhibit);

endmodule

// File: tb/pfc_ready_supervisor_bench.sv
module pfc_ready_supervisor_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0, fault_in = 1'b0, ovp_in = 1'b0, ea_charging = 1'b1;
  logic ready, startup, sw_inhibit, ovp_notice;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pfc_ready_supervisor u_pfc_ready_supervisor (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .fault_in(fault_in),
    .ovp_in(ovp_in), .ea_charging(ea_charging), .ready(ready),
    .startup(startup), .sw_inhibit(sw_inhibit), .ovp_notice(ovp_notice));

  // {run, fault, ovp, chg, exp_ready, exp_startup, exp_inhibit, exp_notice}
  localparam logic [7:0] VEC [13] = '{
    8'b0001_0100, // off, charging: R2
    8'b1001_0100, // active start-up: R3
    8'b1000_1000, // regulation reached: R4
    8'b1100_0000, // fault: R5
    8'b1000_0000, // fault gone, still blocked: R6
    8'b1010_0011, // ovp while active: R8 R9
    8'b0000_0100, // off re-arms: R2
    8'b0010_0110, // ovp while off, no notice: R9
    8'b1001_0100, // restart: R3
    8'b1000_1000, // ready again: R6
    8'b1010_1011, // ovp leaves ready alone: R10
    8'b1001_1000, // charging again, latch stays clear: R3
    8'b0001_0100  // off: R7
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic drive(input logic r, input logic f, input logic o, input logic c);
    @(negedge clk);
    run_en = r; fault_in = f; ovp_in = o; ea_charging = c;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    chk(ready, 1'b0, "R1 ready");
    chk(startup, 1'b1, "R1 startup");
    chk(sw_inhibit, 1'b0, "R1 inhibit");
    chk(ovp_notice, 1'b0, "R1 notice");
    @(negedge clk) rst_n = 1'b1;
    edges(1);
    // R1 right after release
    chk(ready, 1'b0, "R1 ready after release");
    chk(startup, 1'b1, "R1 startup after release");

    foreach (VEC[k]) begin
      drive(VEC[k][7], VEC[k][6], VEC[k][5], VEC[k][4]);
      edges(5);
      chk(ready, VEC[k][3], "R4 ready");
      chk(startup, VEC[k][2], "R3 startup");
      chk(sw_inhibit, VEC[k][1], "R8 inhibit");
      chk(ovp_notice, VEC[k][0], "R9 notice");
    end

    // Reach ready, then time the fault latency (R5, R11)
    drive(1, 0, 0, 0);
    edges(6);
    chk(ready, 1'b1, "R4 ready before fault");
    drive(1, 1, 0, 0);
    edges(2);
    chk(ready, 1'b1, "R11 ready held two edges after fault");
    edges(1);
    chk(ready, 1'b0, "R5 ready low on third edge");
    drive(1, 0, 0, 0);
    edges(8);
    chk(ready, 1'b0, "R6 blocked without off phase");

    // Off phase, restart, then time the off latency (R7, R2)
    drive(0, 0, 0, 1);
    edges(5);
    drive(1, 0, 0, 0);
    edges(6);
    chk(ready, 1'b1, "R6 ready after off and restart");
    drive(0, 0, 0, 0);
    edges(2);
    chk(ready, 1'b1, "R11 ready held two edges after off");
    chk(startup, 1'b0, "R11 startup held two edges after off");
    edges(1);
    chk(ready, 1'b0, "R7 ready low on third edge");
    chk(startup, 1'b1, "R2 startup set on third edge");

    // Over-voltage latency (R8, R11)
    drive(0, 0, 1, 0);
    edges(2);
    chk(sw_inhibit, 1'b0, "R11 inhibit held two edges");
    edges(1);
    chk(sw_inhibit, 1'b1, "R8 inhibit on third edge");
    chk(ovp_notice, 1'b0, "R9 no notice while off");

    summary();
  end
endmodule